// File: doc/BRIEF.md
# Receive Frame-Sync Source Selector

This block decides which signal serves as the receive frame sync of a buffered serial port, and how the shared frame-sync pad behaves. There are three possible sources: the pad input (synchronized, with optional polarity inversion), a local frame-sync generator that counts sample-rate clock ticks, and the transmit-side frame sync. The same control bits also set the pad to input, output or high impedance.

The generator runs in one of two ways. In free-run mode it fires once every programmable number of sample-rate ticks. In slave mode it fires only after a pulse arrives on the pad. In slave mode each detected pad edge also raises a one-cycle resync request toward the external clock divider. Any change to the control inputs restarts the generator count.

Top module: `rx_fsync_sel`

## Requirements
- R1: With loopback 0, clock-stop 00b or 01b and fs_mode 0, rx_fs_o equals pad_fs_i XOR fs_pol_i, delayed by two clk edges through the synchronizer. pad_oe_o is 0 for either value of gen_sync.
- R2: With loopback 0, fs_mode 1 and gen_sync 0, rx_fs_o carries FSG, pad_oe_o is 1 and pad_fs_o equals FSG XOR fs_pol_i.
- R3: In free-run mode FSG goes high on every (frame_per + 1)-th clkg_tick after a reload and stays high until the next tick. With frame_per 0, FSG stays high on every tick.
- R4: With loopback 0, fs_mode 1 and gen_sync 1, pad_oe_o is 0 and frame_per has no effect. A rising edge of the polarity-corrected pad raises resync_req_o for exactly one cycle, after the second clk edge. FSG then goes high on the next clkg_tick and low on the tick after that.
- R5: With loopback 1 and fs_mode 0, rx_fs_o follows tx_fs_i in the same cycle and pad_oe_o is 0.
- R6: With loopback 1 and fs_mode 1, rx_fs_o carries the free-running FSG and pad_oe_o is 0.
- R7: Clock-stop 10b or 11b overrides the other bits: rx_fs_o follows tx_fs_i and pad_oe_o is 0. Clock-stop 00b and 01b leave normal operation unchanged.
- R8: Any change on a control input clears FSG after one clk edge and reloads the count, so the next FSG comes on the (frame_per + 1)-th tick after the change.
- R9: While rst_n is low, and right after it rises, FSG and resync_req_o are 0.
- R10: Outside slave mode, pad edges never raise resync_req_o and do not change FSG timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_fs_i | input | 1 | Frame-sync pad input value |
| tx_fs_i | input | 1 | Internal transmit frame sync |
| clkg_tick_i | input | 1 | One-cycle sample-rate clock tick |
| lpbk_i | input | 1 | Loopback enable |
| fs_mode_i | input | 1 | 0: external/transmit source, 1: generator source |
| gen_sync_i | input | 1 | 1: generator slaved to pad pulses |
| fs_pol_i | input | 1 | 1: invert pad polarity |
| clk_stop_i | input | 2 | Clock-stop mode; 1xb ties receive to transmit |
| frame_per_i | input | PER_W | Frame period minus one, in ticks |
| rx_fs_o | output | 1 | Internal receive frame sync |
| pad_fs_o | output | 1 | Value driven onto the pad |
| pad_oe_o | output | 1 | Pad output enable |
| resync_req_o | output | 1 | One-cycle resync request to the clock divider |

## Verification
The assertions assume clkg_tick_i lasts one cycle per tick. They also assume control inputs are quasi-static: they change only at a configuration boundary and then hold. The timing check for the generator output therefore applies only after two cycles of stable controls. The bench changes controls only inside its configuration task and waits several cycles before it drives ticks. It holds tx_fs_i and pad_fs_i steady except when a scenario toggles them on purpose between clock edges.

// File: rtl/rfs_pkg.sv
// Shared types for the receive frame-sync selector.
// Assumes: nothing beyond the IEEE 1800-2017 type system.
package rfs_pkg;

    // Where the internal receive frame sync is taken from.
    typedef enum logic [1:0] {
        SRC_PAD = 2'd0,
        SRC_GEN = 2'd1,
        SRC_TX  = 2'd2
    } rfs_src_e;

    // Control bits that have no parameterized width.
    typedef struct packed {
        logic       lpbk;
        logic       fs_mode;
        logic       gen_sync;
        logic       pol;
        logic [1:0] clk_stop;
    } rfs_ctrl_t;

    localparam int CTRL_BITS = 6;

endpackage

// File: rtl/rfs_pad_sync.sv
// Pad synchronizer and rising-edge detector.
// Applies the polarity inversion, then passes the pad through STAGES flops.
// rise_o is high for one cycle when the synchronized level goes 0 -> 1.
// Assumes: STAGES >= 2; the pad is asynchronous to clk.
module rfs_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic pol_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Capture the polarity-corrected pad and shift it along the chain.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pad_i ^ pol_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // Synchronized level and its rising edge.
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = chain_q[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/rfs_ctrl_watch.sv
// Control change detector.
// Registers the packed control vector. chg_o is high in any cycle where
// the live vector differs from the registered copy.
// Assumes: controls are quasi-static, written from a register bank.
module rfs_ctrl_watch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec_i,
    output logic         chg_o
);

    logic [W-1:0] vec_q;

    // Keep the previous control vector.
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_i;
    end

    // Flag any difference.
    always_comb chg_o = (vec_i != vec_q);

endmodule

// File: rtl/rfs_fsg_gen.sv
// Frame-sync generator.
// Free-run: fsg_o rises on every (per_i + 1)-th tick and holds until the next tick.
// Slave: fsg_o rises on the first tick after a trigger and falls on the tick after that.
// reload_i clears fsg_o and any pending trigger, and loads the count.
// Assumes: tick_i is a one-cycle strobe.
module rfs_fsg_gen #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             slave_i,
    input  logic             trig_i,
    input  logic             reload_i,
    input  logic [PER_W-1:0] per_i,
    output logic             fsg_o
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt_q;
    logic             fsg_q;
    logic             pend_q;

    // Count ticks (free-run) or wait for a trigger (slave), and form FSG.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fsg_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (reload_i) begin
            cnt_q  <= per_i;
            fsg_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (slave_i) begin
            cnt_q <= per_i;
            if (tick_i) begin
                fsg_q  <= pend_q | trig_i;
                pend_q <= 1'b0;
            end else if (trig_i) begin
                pend_q <= 1'b1;
            end
        end else begin
            pend_q <= 1'b0;
            if (tick_i) begin
                if (cnt_q == '0) begin
                    fsg_q <= 1'b1;
                    cnt_q <= per_i;
                end else begin
                    fsg_q <= 1'b0;
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    // Generator output.
    always_comb fsg_o = fsg_q;

endmodule

// File: rtl/rfs_route.sv
// Source and pad-direction decoder.
// Turns the control bits into a source choice, the pad output enable and
// the slave-mode flag. Clock-stop 1xb has the highest priority, then loopback.
// Assumes: pure combinational decode; inputs are register outputs.
module rfs_route
    import rfs_pkg::*;
(
    input  rfs_ctrl_t ctrl_i,
    output rfs_src_e  src_o,
    output logic      oe_o,
    output logic      slave_o
);

    // Decode the control bits by priority.
    always_comb begin
        src_o   = SRC_PAD;
        oe_o    = 1'b0;
        slave_o = 1'b0;
        if (ctrl_i.clk_stop[1]) begin
            src_o = SRC_TX;
        end else if (ctrl_i.lpbk) begin
            src_o = ctrl_i.fs_mode ? SRC_GEN : SRC_TX;
        end else if (ctrl_i.fs_mode) begin
            src_o   = SRC_GEN;
            oe_o    = ~ctrl_i.gen_sync;
            slave_o = ctrl_i.gen_sync;
        end
    end

endmodule

// File: rtl/rx_fsync_sel.sv
// Receive frame-sync selector top.
// Picks the pad, generator or transmit frame sync as the receive frame sync,
// drives the pad direction and value, and raises resync requests in slave mode.
// Assumes: clkg_tick_i is a one-cycle strobe in the clk domain; controls are quasi-static.
module rx_fsync_sel
    import rfs_pkg::*;
#(
    parameter int PER_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_fs_i,
    input  logic             tx_fs_i,
    input  logic             clkg_tick_i,
    input  logic             lpbk_i,
    input  logic             fs_mode_i,
    input  logic             gen_sync_i,
    input  logic             fs_pol_i,
    input  logic [1:0]       clk_stop_i,
    input  logic [PER_W-1:0] frame_per_i,
    output logic             rx_fs_o,
    output logic             pad_fs_o,
    output logic             pad_oe_o,
    output logic             resync_req_o
);

    localparam int CW = CTRL_BITS + PER_W;

    rfs_ctrl_t ctrl;
    rfs_src_e  src;
    logic      oe;
    logic      slave;
    logic      pad_lvl;
    logic      pad_rise;
    logic      chg;
    logic      fsg;

    // Gather the control bits.
    always_comb begin
        ctrl.lpbk     = lpbk_i;
        ctrl.fs_mode  = fs_mode_i;
        ctrl.gen_sync = gen_sync_i;
        ctrl.pol      = fs_pol_i;
        ctrl.clk_stop = clk_stop_i;
    end

    rfs_route u_route (
        .ctrl_i  (ctrl),
        .src_o   (src),
        .oe_o    (oe),
        .slave_o (slave)
    );

    rfs_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_fs_i),
        .pol_i   (fs_pol_i),
        .level_o (pad_lvl),
        .rise_o  (pad_rise)
    );

    rfs_ctrl_watch #(.W(CW)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .vec_i ({ctrl, frame_per_i}),
        .chg_o (chg)
    );

    rfs_fsg_gen #(.PER_W(PER_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (clkg_tick_i),
        .slave_i  (slave),
        .trig_i   (pad_rise),
        .reload_i (chg),
        .per_i    (frame_per_i),
        .fsg_o    (fsg)
    );

    // Select the receive frame sync and drive the pad.
    always_comb begin
        unique case (src)
            SRC_GEN: rx_fs_o = fsg;
            SRC_TX:  rx_fs_o = tx_fs_i;
            default: rx_fs_o = pad_lvl;
        endcase
        pad_oe_o     = oe;
        pad_fs_o     = oe ? (fsg ^ fs_pol_i) : 1'b0;
        resync_req_o = pad_rise & slave;
    end

endmodule

// File: rtl/rx_fsync_sel_chk.sv
// Assertion checker for rx_fsync_sel, attached by bind.
// Assumes: one-cycle ticks and quasi-static controls.
module rx_fsync_sel_chk #(
    parameter int PER_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_fs_i,
    input logic             clkg_tick_i,
    input logic             lpbk_i,
    input logic             fs_mode_i,
    input logic             gen_sync_i,
    input logic             fs_pol_i,
    input logic [1:0]       clk_stop_i,
    input logic [PER_W-1:0] frame_per_i,
    input logic             rx_fs_o,
    input logic             pad_fs_o,
    input logic             pad_oe_o,
    input logic             resync_req_o
);

    logic [PER_W+5:0] cv;
    logic             gen_src;
    logic             slave_md;

    // Helper terms derived from the ports.
    always_comb begin
        cv       = {lpbk_i, fs_mode_i, gen_sync_i, fs_pol_i, clk_stop_i, frame_per_i};
        gen_src  = !clk_stop_i[1] && fs_mode_i;
        slave_md = !clk_stop_i[1] && !lpbk_i && fs_mode_i && gen_sync_i;
    end

    p_pad_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_stop_i[1] && !lpbk_i && !fs_mode_i) |-> !pad_oe_o);

    p_pad_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe_o |-> (pad_fs_o == (rx_fs_o ^ fs_pol_i)));

    p_fsg_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_src && $stable(cv) && $past($stable(cv)) && !$past(clkg_tick_i))
        |-> $stable(rx_fs_o));

    p_resync_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req_o |=> !resync_req_o);

    p_loop_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_i && !fs_mode_i) |-> (rx_fs_o == tx_fs_i && !pad_oe_o));

    p_loop_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_i && fs_mode_i) |-> !pad_oe_o);

    p_clkstop_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_i[1] |-> (rx_fs_o == tx_fs_i && !pad_oe_o));

    p_resync_slave_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req_o |-> slave_md);

endmodule

bind rx_fsync_sel rx_fsync_sel_chk #(.PER_W(PER_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_fs_i      (tx_fs_i),
    .clkg_tick_i  (clkg_tick_i),
    .lpbk_i       (lpbk_i),
    .fs_mode_i    (fs_mode_i),
    .gen_sync_i   (gen_sync_i),
    .fs_pol_i     (fs_pol_i),
    .clk_stop_i   (clk_stop_i),
    .frame_per_i  (frame_per_i),
    .rx_fs_o      (rx_fs_o),
    .pad_fs_o     (pad_fs_o),
    .pad_oe_o     (pad_oe_o),
    .resync_req_o (resync_req_o)
);

// File: tb/rx_fsync_sel_tb.sv
// Directed bench for rx_fsync_sel: one task per scenario.
module rx_fsync_sel_tb;

    localparam int PER_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pad_fs_i = 1'b0;
    logic             tx_fs_i = 1'b0;
    logic             clkg_tick_i = 1'b0;
    logic             lpbk_i = 1'b0;
    logic             fs_mode_i = 1'b1;
    logic             gen_sync_i = 1'b0;
    logic             fs_pol_i = 1'b1;
    logic [1:0]       clk_stop_i = 2'b00;
    logic [PER_W-1:0] frame_per_i = 8'd3;
    logic             rx_fs_o;
    logic             pad_fs_o;
    logic             pad_oe_o;
    logic             resync_req_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rx_fsync_sel #(.PER_W(PER_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pad_fs_i     (pad_fs_i),
        .tx_fs_i      (tx_fs_i),
        .clkg_tick_i  (clkg_tick_i),
        .lpbk_i       (lpbk_i),
        .fs_mode_i    (fs_mode_i),
        .gen_sync_i   (gen_sync_i),
        .fs_pol_i     (fs_pol_i),
        .clk_stop_i   (clk_stop_i),
        .frame_per_i  (frame_per_i),
        .rx_fs_o      (rx_fs_o),
        .pad_fs_o     (pad_fs_o),
        .pad_oe_o     (pad_oe_o),
        .resync_req_o (resync_req_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a configuration; a dummy period first forces a reload.
    task automatic set_cfg(input logic lp, input logic md, input logic gs,
                           input logic pl, input logic [1:0] cs,
                           input logic [PER_W-1:0] per);
        @(negedge clk);
        frame_per_i = ~per;
        @(negedge clk);
        lpbk_i = lp; fs_mode_i = md; gen_sync_i = gs;
        fs_pol_i = pl; clk_stop_i = cs; frame_per_i = per;
        repeat (3) @(negedge clk);
    endtask

    // One sample-rate tick; returns at the negedge after it was taken.
    task automatic tick_once();
        clkg_tick_i = 1'b1;
        @(negedge clk);
        clkg_tick_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        check("R9 rx_fs in reset", rx_fs_o, 0);
        check("R9 resync in reset", resync_req_o, 0);
        check("R2 oe in reset master", pad_oe_o, 1);
        check("R2 pad value in reset", pad_fs_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rx_fs after reset", rx_fs_o, 0);
        check("R9 resync after reset", resync_req_o, 0);
    endtask

    task automatic t_free_run();
        set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 8'd3);
        for (int k = 1; k <= 12; k++) begin
            tick_once();
            check("R3 free-run period", rx_fs_o, (k % 4 == 0) ? 1 : 0);
            check("R2 pad drives FSG inverted", pad_fs_o, (k % 4 == 0) ? 0 : 1);
            check("R2 pad is output", pad_oe_o, 1);
        end
    endtask

    task automatic t_per_zero();
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 8'd0);
        for (int k = 1; k <= 4; k++) begin
            tick_once();
            check("R3 frame_per zero", rx_fs_o, 1);
            check("R7 clock-stop 01 normal oe", pad_oe_o, 1);
        end
    endtask

    task automatic t_reload();
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'd1);
        tick_once();
        tick_once();
        check("R8 FSG high before change", rx_fs_o, 1);
        frame_per_i = 8'd3;
        @(negedge clk);
        check("R8 FSG cleared by change", rx_fs_o, 0);
        @(negedge clk);
        for (int k = 1; k <= 4; k++) begin
            tick_once();
            check("R8 period after reload", rx_fs_o, (k == 4) ? 1 : 0);
        end
    endtask

    task automatic t_pad_in();
        for (int gs = 0; gs < 2; gs++) begin
            pad_fs_i = 1'b1;
            set_cfg(1'b0, 1'b0, gs[0], 1'b1, 2'b00, 8'd2);
            check("R1 pad idle inverted", rx_fs_o, 0);
            check("R1 pad is input", pad_oe_o, 0);
            pad_fs_i = 1'b0;
            @(negedge clk);
            check("R1 one edge not yet", rx_fs_o, 0);
            @(negedge clk);
            check("R1 two edges through", rx_fs_o, 1);
            check("R10 no resync in pad mode", resync_req_o, 0);
            tick_once();
            check("R1 tick has no effect", rx_fs_o, 1);
            pad_fs_i = 1'b1;
            repeat (3) @(negedge clk);
            check("R1 pad back", rx_fs_o, 0);
        end
    endtask

    task automatic t_slave();
        pad_fs_i = 1'b0;
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'd2);
        check("R4 pad is input", pad_oe_o, 0);
        for (int k = 1; k <= 6; k++) begin
            tick_once();
            check("R4 period ignored", rx_fs_o, 0);
        end
        pad_fs_i = 1'b1;
        @(negedge clk);
        check("R4 resync not after one edge", resync_req_o, 0);
        @(negedge clk);
        check("R4 resync raised", resync_req_o, 1);
        @(negedge clk);
        check("R4 resync one cycle", resync_req_o, 0);
        pad_fs_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 FSG waits for tick", rx_fs_o, 0);
        tick_once();
        check("R4 FSG on next tick", rx_fs_o, 1);
        tick_once();
        check("R4 FSG falls on following tick", rx_fs_o, 0);
        tick_once();
        check("R4 FSG stays low", rx_fs_o, 0);
    endtask

    task automatic t_no_resync();
        set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 8'd3);
        for (int k = 1; k <= 8; k++) begin
            pad_fs_i = ~pad_fs_i;
            repeat (3) begin
                @(negedge clk);
                check("R10 no resync in free-run", resync_req_o, 0);
            end
            tick_once();
            check("R10 FSG timing undisturbed", rx_fs_o, (k % 4 == 0) ? 1 : 0);
        end
        pad_fs_i = 1'b0;
    endtask

    task automatic t_loop_tx();
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'd0);
        for (int v = 0; v < 2; v++) begin
            tx_fs_i = v[0];
            #1;
            check("R5 loopback follows tx", rx_fs_o, v);
            check("R5 pad high impedance", pad_oe_o, 0);
            @(negedge clk);
        end
        tx_fs_i = 1'b0;
    endtask

    task automatic t_loop_gen();
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 8'd1);
        for (int k = 1; k <= 4; k++) begin
            tick_once();
            check("R6 loopback FSG", rx_fs_o, (k % 2 == 0) ? 1 : 0);
            check("R6 pad high impedance", pad_oe_o, 0);
        end
    endtask

    task automatic t_clkstop();
        for (int c = 2; c < 4; c++) begin
            set_cfg(1'b0, 1'b1, 1'b0, 1'b0, c[1:0], 8'd1);
            for (int v = 0; v < 2; v++) begin
                tx_fs_i = v[0];
                #1;
                check("R7 clock-stop ties to tx", rx_fs_o, v);
                check("R7 clock-stop pad off", pad_oe_o, 0);
                @(negedge clk);
            end
        end
        tx_fs_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R1..all run hung actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_per_zero();
        t_reload();
        t_pad_in();
        t_slave();
        t_no_resync();
        t_loop_tx();
        t_loop_gen();
        t_clkstop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule